// File: doc/BRIEF.md
# L2 Snoop and Backoff Line Controller

This block keeps the MESI state of a small set of lines in a second-level write-back cache. The cache sits between one processor's first-level cache and a bus that it shares with another master. It has two roles: it answers snoops from the other master, and it runs the local processor's requests to the bus. Tag lookup, data storage and memory timing sit outside the block. The line index arrives already resolved, and every handshake is a plain request/acknowledge pair.

When a snoop hits a line held Exclusive or Modified, the block holds the requester off with three low outputs: the hit indication, the dirty-hit indication and the hold request. It then snoops the first-level cache, telling it whether to drop its copy. If either level holds dirty data, it writes the line back to memory. After that it releases all three outputs for one cycle. On a snoop read it then pulses the hit indication once more to mark the line as shared.

As a requester, the block fills lines as Exclusive or Shared. It uses its response flag to grant ownership to the first-level cache only on the first write to an owned line, so that first write passes through to the L2 and every later write stays in the first-level cache. A hold from the other side aborts the pending bus request, and the block retries it once the hold is lifted.

Top module: `l2snp_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. The outputs `snp_hit_n`, `snp_dirty_n` and `hold_req_n` are high, the three request outputs are low, and both ready outputs are high.
- R2: A snoop accepted on a line in E or M drives `snp_hit_n`, `snp_dirty_n` and `hold_req_n` low from the next cycle until the release cycle.
- R3: While the hold is active, the block raises `l1_snp_req` with `l1_snp_kill`=0 for a snoop read and 1 for a snoop write, and keeps it steady until `l1_snp_ack`.
- R4: After the L1 acknowledge, `mem_wb_req` is raised when the line was M or `l1_snp_dirty` was 1. A clean E line skips the write-back.
- R5: In the release cycle all three snoop outputs are high. The line becomes S after a snoop read and I after a snoop write.
- R6: After the release on a snoop read, `snp_hit_n` is low for one cycle while `snp_dirty_n` and `hold_req_n` stay high.
- R7: A snoop read to an S line only pulses `snp_hit_n` low for one cycle, with no L1 snoop and no hold. A snoop to an I line produces no activity.
- R8: A snoop write to an S line makes it I and snoops the L1 with `l1_snp_kill`=1, without asserting the hold.
- R9: A read miss issues a bus read (`bus_op`=0). On `bus_ack` the line becomes E if `fill_shared_n` is high and S if it is low. `rsp_l1_own` is 0. A read hit responds without a bus cycle and with `rsp_l1_own`=0.
- R10: A write to an E line makes it M and responds with `rsp_l1_own`=1, with no bus cycle. A write to an M line also responds with `rsp_l1_own`=1 and no bus cycle.
- R11: A write to an S line issues a bus write (`bus_op`=1) to invalidate the other copy, then the line becomes E with `rsp_l1_own`=0. A write to an I line issues a bus write, leaves the line I and responds with `rsp_l1_own`=0.
- R12: When `hold_in_n` is low, `bus_req` is low in the next cycle. The request is issued again after `hold_in_n` returns high.
- R13: Only one snoop is processed at a time. `snp_ready` and `cpu_ready` stay low from acceptance until after the `snp_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snp_valid | input | 1 | Snoop from the other master present |
| snp_write | input | 1 | Snoop is a write (1) or read (0) |
| snp_idx | input | IDX_W | Line index of the snoop |
| snp_ready | output | 1 | Snoop can be accepted |
| snp_done | output | 1 | One-cycle pulse at the end of a snoop |
| snp_hit_n | output | 1 | Low: line present here |
| snp_dirty_n | output | 1 | Low: line owned here and held off |
| hold_req_n | output | 1 | Low: requester must back off |
| l1_snp_req | output | 1 | Snoop request to the L1 |
| l1_snp_kill | output | 1 | L1 must invalidate its copy |
| l1_snp_idx | output | IDX_W | Line index of the L1 snoop |
| l1_snp_ack | input | 1 | L1 snoop finished (including any L1 write-back) |
| l1_snp_dirty | input | 1 | L1 copy was modified (with ack) |
| mem_wb_req | output | 1 | Write-back request to memory |
| mem_wb_idx | output | IDX_W | Line index of the write-back |
| mem_wb_ack | input | 1 | Write-back finished |
| cpu_valid | input | 1 | Local processor request present |
| cpu_write | input | 1 | Request is a write |
| cpu_idx | input | IDX_W | Line index of the request |
| cpu_ready | output | 1 | Request can be accepted |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_l1_own | output | 1 | L1 may hold the line as owner |
| bus_req | output | 1 | Bus cycle request |
| bus_op | output | 1 | 0 read fill, 1 write/invalidate |
| bus_idx | output | IDX_W | Line index of the bus cycle |
| bus_ack | input | 1 | Bus cycle finished |
| fill_shared_n | input | 1 | Low: other cache hit during the fill |
| hold_in_n | input | 1 | Low: this block must back off |

## Verification
The assertions assume that each acknowledge arrives only while its own request is high and lasts a single cycle. They also assume that `l1_snp_dirty` is reported only for lines the L1 may own. The bench's responders acknowledge only pending requests, after a fixed count of cycles, and report dirty L1 data only for lines held E here. Requests are presented only while the matching ready is high and withdrawn after acceptance. The one hold from the other side is applied while a fill is pending.

// File: rtl/l2snp_pkg.sv
package l2snp_pkg;
  typedef enum logic [1:0] {
    MESI_I = 2'b00,
    MESI_S = 2'b01,
    MESI_E = 2'b10,
    MESI_M = 2'b11
  } mesi_e;

  typedef enum logic [2:0] {
    SN_IDLE, SN_L1, SN_WB, SN_REL, SN_SHR, SN_END
  } sn_state_e;

  typedef enum logic [1:0] {
    RQ_IDLE, RQ_BUS, RQ_HOLD, RQ_RSP
  } rq_state_e;

  typedef enum logic [1:0] {
    K_FILL, K_INV, K_THRU
  } rq_kind_e;
endpackage

// File: rtl/l2snp_line_store.sv
module l2snp_line_store
  import l2snp_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] sn_rd_idx,
  input  logic [IDX_W-1:0] rq_rd_idx,
  output mesi_e            sn_rd_st,
  output mesi_e            rq_rd_st,
  input  logic             sn_we,
  input  logic [IDX_W-1:0] sn_wr_idx,
  input  mesi_e            sn_wr_st,
  input  logic             rq_we,
  input  logic [IDX_W-1:0] rq_wr_idx,
  input  mesi_e            rq_wr_st
);
  mesi_e line_st [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    mesi_e st_q;
    mesi_e st_d;
    logic  st_en;

    // snoop updates take priority over requester updates on the same line
    always_comb begin
      st_en = 1'b0;
      st_d  = st_q;
      if (sn_we && sn_wr_idx == IDX_W'(g)) begin
        st_en = 1'b1;
        st_d  = sn_wr_st;
      end else if (rq_we && rq_wr_idx == IDX_W'(g)) begin
        st_en = 1'b1;
        st_d  = rq_wr_st;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= MESI_I;
      else if (st_en) st_q <= st_d;
    end

    assign line_st[g] = st_q;
  end

  assign sn_rd_st = line_st[sn_rd_idx];
  assign rq_rd_st = line_st[rq_rd_idx];
endmodule

// File: rtl/l2snp_snoop_seq.sv
module l2snp_snoop_seq
  import l2snp_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid,
  input  logic             snp_write,
  input  logic [IDX_W-1:0] snp_idx,
  input  mesi_e            line_st,
  output logic             snp_ready,
  output logic             snp_done,
  output logic             snp_hit_n,
  output logic             snp_dirty_n,
  output logic             hold_req_n,
  output logic             l1_req,
  output logic             l1_kill,
  output logic [IDX_W-1:0] l1_idx,
  input  logic             l1_ack,
  input  logic             l1_dirty,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_idx,
  input  logic             wb_ack,
  output logic             st_we,
  output logic [IDX_W-1:0] st_idx,
  output mesi_e            st_val
);
  sn_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic             wr_q, hold_q, dirty_q;
  logic             hold_d, dirty_d;
  logic             accept, dirty_en;
  logic             hold_active;

  always_comb begin
    state_d  = state_q;
    hold_d   = hold_q;
    dirty_d  = dirty_q;
    dirty_en = 1'b0;
    accept   = 1'b0;
    st_we    = 1'b0;
    st_val   = MESI_I;
    snp_done = 1'b0;
    unique case (state_q)
      SN_IDLE: if (snp_valid) begin
        accept   = 1'b1;
        dirty_en = 1'b1;
        hold_d   = 1'b0;
        dirty_d  = 1'b0;
        unique case (line_st)
          MESI_I: state_d = SN_END;
          MESI_S: begin
            if (snp_write) begin
              st_we   = 1'b1;
              st_val  = MESI_I;
              state_d = SN_L1;
            end else begin
              state_d = SN_SHR;
            end
          end
          default: begin
            hold_d  = 1'b1;
            dirty_d = (line_st == MESI_M);
            state_d = SN_L1;
          end
        endcase
      end
      SN_L1: if (l1_ack) begin
        dirty_en = 1'b1;
        dirty_d  = dirty_q | l1_dirty;
        if (!hold_q)                     state_d = SN_END;
        else if (dirty_q | l1_dirty)     state_d = SN_WB;
        else                             state_d = SN_REL;
      end
      SN_WB: if (wb_ack) state_d = SN_REL;
      SN_REL: begin
        st_we   = 1'b1;
        st_val  = wr_q ? MESI_I : MESI_S;
        state_d = wr_q ? SN_END : SN_SHR;
      end
      SN_SHR: state_d = SN_END;
      SN_END: begin
        snp_done = 1'b1;
        state_d  = SN_IDLE;
      end
      default: state_d = SN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SN_IDLE;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      hold_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        idx_q  <= snp_idx;
        wr_q   <= snp_write;
        hold_q <= hold_d;
      end
      if (dirty_en) dirty_q <= dirty_d;
    end
  end

  assign hold_active = hold_q && (state_q == SN_L1 || state_q == SN_WB);
  assign snp_ready   = (state_q == SN_IDLE);
  assign snp_hit_n   = !(hold_active || state_q == SN_SHR);
  assign snp_dirty_n = !hold_active;
  assign hold_req_n  = !hold_active;
  assign l1_req      = (state_q == SN_L1);
  assign l1_kill     = wr_q;
  assign l1_idx      = idx_q;
  assign wb_req      = (state_q == SN_WB);
  assign wb_idx      = idx_q;
  assign st_idx      = (state_q == SN_IDLE) ? snp_idx : idx_q;
endmodule

// File: rtl/l2snp_req_seq.sv
module l2snp_req_seq
  import l2snp_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  input  logic             cpu_write,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             snoop_idle,
  input  logic             snp_valid,
  input  mesi_e            line_st,
  output logic             cpu_ready,
  output logic             rsp_valid,
  output logic             rsp_l1_own,
  output logic             bus_req,
  output logic             bus_op,
  output logic [IDX_W-1:0] bus_idx,
  input  logic             bus_ack,
  input  logic             fill_shared_n,
  input  logic             hold_in_n,
  output logic             st_we,
  output logic [IDX_W-1:0] st_idx,
  output mesi_e            st_val
);
  rq_state_e        state_q, state_d;
  rq_kind_e         kind_q, kind_d;
  logic [IDX_W-1:0] idx_q;
  logic             own_q, own_d;
  logic             accept, go_bus;

  assign cpu_ready = (state_q == RQ_IDLE) && snoop_idle && !snp_valid;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    own_d   = 1'b0;
    accept  = 1'b0;
    go_bus  = 1'b0;
    st_we   = 1'b0;
    st_val  = MESI_I;
    unique case (state_q)
      RQ_IDLE: if (cpu_valid && cpu_ready) begin
        accept = 1'b1;
        if (!cpu_write) begin
          if (line_st == MESI_I) begin
            kind_d = K_FILL;
            go_bus = 1'b1;
          end else begin
            state_d = RQ_RSP;
          end
        end else begin
          unique case (line_st)
            MESI_M: begin
              own_d   = 1'b1;
              state_d = RQ_RSP;
            end
            MESI_E: begin
              st_we   = 1'b1;
              st_val  = MESI_M;
              own_d   = 1'b1;
              state_d = RQ_RSP;
            end
            MESI_S: begin
              kind_d = K_INV;
              go_bus = 1'b1;
            end
            default: begin
              kind_d = K_THRU;
              go_bus = 1'b1;
            end
          endcase
        end
        if (go_bus) state_d = hold_in_n ? RQ_BUS : RQ_HOLD;
      end
      RQ_BUS: begin
        if (!hold_in_n) begin
          state_d = RQ_HOLD;
        end else if (bus_ack) begin
          unique case (kind_q)
            K_FILL: begin
              st_we  = 1'b1;
              st_val = fill_shared_n ? MESI_E : MESI_S;
            end
            K_INV: begin
              st_we  = 1'b1;
              st_val = MESI_E;
            end
            default: st_we = 1'b0;
          endcase
          state_d = RQ_RSP;
        end
      end
      RQ_HOLD: if (hold_in_n) state_d = RQ_BUS;
      RQ_RSP:  state_d = RQ_IDLE;
      default: state_d = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RQ_IDLE;
      kind_q  <= K_FILL;
      idx_q   <= '0;
      own_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        kind_q <= kind_d;
        idx_q  <= cpu_idx;
        own_q  <= own_d;
      end
    end
  end

  assign bus_req    = (state_q == RQ_BUS);
  assign bus_op     = (kind_q != K_FILL);
  assign bus_idx    = idx_q;
  assign rsp_valid  = (state_q == RQ_RSP);
  assign rsp_l1_own = own_q;
  assign st_idx     = (state_q == RQ_IDLE) ? cpu_idx : idx_q;
endmodule

// File: rtl/l2snp_line_ctrl.sv
module l2snp_line_ctrl
  import l2snp_pkg::*;
#(
  parameter  int NUM_LINES = 4,
  localparam int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid,
  input  logic             snp_write,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             snp_ready,
  output logic             snp_done,
  output logic             snp_hit_n,
  output logic             snp_dirty_n,
  output logic             hold_req_n,
  output logic             l1_snp_req,
  output logic             l1_snp_kill,
  output logic [IDX_W-1:0] l1_snp_idx,
  input  logic             l1_snp_ack,
  input  logic             l1_snp_dirty,
  output logic             mem_wb_req,
  output logic [IDX_W-1:0] mem_wb_idx,
  input  logic             mem_wb_ack,
  input  logic             cpu_valid,
  input  logic             cpu_write,
  input  logic [IDX_W-1:0] cpu_idx,
  output logic             cpu_ready,
  output logic             rsp_valid,
  output logic             rsp_l1_own,
  output logic             bus_req,
  output logic             bus_op,
  output logic [IDX_W-1:0] bus_idx,
  input  logic             bus_ack,
  input  logic             fill_shared_n,
  input  logic             hold_in_n
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mesi_e            sn_rd_st, rq_rd_st, sn_wr_st, rq_wr_st;
  logic             sn_we, rq_we;
  logic [IDX_W-1:0] sn_wr_idx, rq_wr_idx;

  l2snp_line_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sn_rd_idx (snp_idx),
    .rq_rd_idx (cpu_idx),
    .sn_rd_st  (sn_rd_st),
    .rq_rd_st  (rq_rd_st),
    .sn_we     (sn_we),
    .sn_wr_idx (sn_wr_idx),
    .sn_wr_st  (sn_wr_st),
    .rq_we     (rq_we),
    .rq_wr_idx (rq_wr_idx),
    .rq_wr_st  (rq_wr_st)
  );

  l2snp_snoop_seq #(.IDX_W(IDX_W)) u_snoop (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .snp_valid   (snp_valid),
    .snp_write   (snp_write),
    .snp_idx     (snp_idx),
    .line_st     (sn_rd_st),
    .snp_ready   (snp_ready),
    .snp_done    (snp_done),
    .snp_hit_n   (snp_hit_n),
    .snp_dirty_n (snp_dirty_n),
    .hold_req_n  (hold_req_n),
    .l1_req      (l1_snp_req),
    .l1_kill     (l1_snp_kill),
    .l1_idx      (l1_snp_idx),
    .l1_ack      (l1_snp_ack),
    .l1_dirty    (l1_snp_dirty),
    .wb_req      (mem_wb_req),
    .wb_idx      (mem_wb_idx),
    .wb_ack      (mem_wb_ack),
    .st_we       (sn_we),
    .st_idx      (sn_wr_idx),
    .st_val      (sn_wr_st)
  );

  l2snp_req_seq #(.IDX_W(IDX_W)) u_req (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .cpu_valid     (cpu_valid),
    .cpu_write     (cpu_write),
    .cpu_idx       (cpu_idx),
    .snoop_idle    (snp_ready),
    .snp_valid     (snp_valid),
    .line_st       (rq_rd_st),
    .cpu_ready     (cpu_ready),
    .rsp_valid     (rsp_valid),
    .rsp_l1_own    (rsp_l1_own),
    .bus_req       (bus_req),
    .bus_op        (bus_op),
    .bus_idx       (bus_idx),
    .bus_ack       (bus_ack),
    .fill_shared_n (fill_shared_n),
    .hold_in_n     (hold_in_n),
    .st_we         (rq_we),
    .st_idx        (rq_wr_idx),
    .st_val        (rq_wr_st)
  );
endmodule

// File: rtl/l2snp_line_ctrl_chk.sv
module l2snp_line_ctrl_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             snp_valid,
  input logic             snp_ready,
  input logic             snp_done,
  input logic             snp_hit_n,
  input logic             snp_dirty_n,
  input logic             hold_req_n,
  input logic             l1_snp_req,
  input logic             l1_snp_kill,
  input logic [IDX_W-1:0] l1_snp_idx,
  input logic             l1_snp_ack,
  input logic             mem_wb_req,
  input logic             mem_wb_ack,
  input logic             cpu_ready,
  input logic             bus_req,
  input logic             hold_in_n
);
  assert_hold_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req_n) |-> $past(snp_valid && snp_ready));

  assert_hold_with_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_req_n |-> (!snp_hit_n && !snp_dirty_n));

  assert_l1_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_snp_req && !l1_snp_ack) |=> (l1_snp_req && $stable(l1_snp_kill) && $stable(l1_snp_idx)));

  assert_wb_under_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wb_req |-> !hold_req_n);

  assert_wb_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wb_req && !mem_wb_ack) |=> mem_wb_req);

  assert_release_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req_n) |-> (snp_hit_n && snp_dirty_n && !mem_wb_req && !l1_snp_req));

  assert_abort_on_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_in_n |=> !bus_req);

  assert_one_snoop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_ready |-> !cpu_ready);

  assert_done_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    snp_done |-> (!snp_ready && $onehot0({l1_snp_req, mem_wb_req})));
endmodule

bind l2snp_line_ctrl l2snp_line_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .snp_valid   (snp_valid),
  .snp_ready   (snp_ready),
  .snp_done    (snp_done),
  .snp_hit_n   (snp_hit_n),
  .snp_dirty_n (snp_dirty_n),
  .hold_req_n  (hold_req_n),
  .l1_snp_req  (l1_snp_req),
  .l1_snp_kill (l1_snp_kill),
  .l1_snp_idx  (l1_snp_idx),
  .l1_snp_ack  (l1_snp_ack),
  .mem_wb_req  (mem_wb_req),
  .mem_wb_ack  (mem_wb_ack),
  .cpu_ready   (cpu_ready),
  .bus_req     (bus_req),
  .hold_in_n   (hold_in_n)
);

// File: tb/l2snp_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module l2snp_line_ctrl_tb_top;
  localparam int IDX_W = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic snp_valid, snp_write;
  logic [IDX_W-1:0] snp_idx;
  logic snp_ready, snp_done, snp_hit_n, snp_dirty_n, hold_req_n;
  logic l1_snp_req, l1_snp_kill, l1_snp_ack, l1_snp_dirty;
  logic [IDX_W-1:0] l1_snp_idx;
  logic mem_wb_req, mem_wb_ack;
  logic [IDX_W-1:0] mem_wb_idx;
  logic cpu_valid, cpu_write, cpu_ready, rsp_valid, rsp_l1_own;
  logic [IDX_W-1:0] cpu_idx;
  logic bus_req, bus_op, bus_ack, fill_shared_n, hold_in_n;
  logic [IDX_W-1:0] bus_idx;

  l2snp_line_ctrl #(.NUM_LINES(4)) dut_i (.*);

  typedef struct {
    bit          is_rsp;
    logic [5:0]  val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int  n_chk = 0;
  int  n_bad = 0;
  bit  dirty_cfg = 1'b0;
  bit  hold_arm = 1'b0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // snoop signature {hold, dirty_hit, l1_snoop, kill, writeback, shared_pulse}
  task automatic snoop(input logic [IDX_W-1:0] idx, input bit wr, input bit l1d,
                       input logic [5:0] exp_sig, input string tag);
    exp_t e;
    e.is_rsp = 1'b0; e.val = exp_sig; e.tag = tag;
    exp_q.push_back(e);
    while (!snp_ready) @(negedge clk);
    dirty_cfg = l1d;
    snp_valid = 1'b1; snp_write = wr; snp_idx = idx;
    @(negedge clk);
    snp_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // response signature {00, l1_own, bus_op, bus_issue_count[1:0]}
  task automatic cpu(input logic [IDX_W-1:0] idx, input bit wr, input bit shared_n,
                     input bit do_hold, input logic [5:0] exp_rsp, input string tag);
    exp_t e;
    e.is_rsp = 1'b1; e.val = exp_rsp; e.tag = tag;
    exp_q.push_back(e);
    while (!cpu_ready) @(negedge clk);
    fill_shared_n = shared_n;
    hold_arm = do_hold;
    cpu_valid = 1'b1; cpu_write = wr; cpu_idx = idx;
    @(negedge clk);
    cpu_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // responders: L1 after 2 cycles, memory after 3, bus after 3
  initial begin
    int l1_cnt = 0, wb_cnt = 0, bus_cnt = 0, hold_cnt = 0;
    l1_snp_ack = 0; l1_snp_dirty = 0; mem_wb_ack = 0; bus_ack = 0; hold_in_n = 1;
    forever begin
      @(negedge clk);
      l1_snp_ack = 1'b0; mem_wb_ack = 1'b0; bus_ack = 1'b0;
      if (l1_snp_req) begin
        l1_cnt++;
        if (l1_cnt == 2) begin l1_snp_ack = 1'b1; l1_snp_dirty = dirty_cfg; l1_cnt = 0; end
      end
      if (mem_wb_req) begin
        wb_cnt++;
        if (wb_cnt == 3) begin mem_wb_ack = 1'b1; wb_cnt = 0; end
      end
      if (hold_cnt > 0) begin
        hold_cnt--;
        if (hold_cnt == 0) hold_in_n = 1'b1;
      end else if (bus_req) begin
        bus_cnt++;
        if (hold_arm && bus_cnt == 1) begin
          hold_in_n = 1'b0; hold_cnt = 3; hold_arm = 1'b0; bus_cnt = 0;
        end else if (bus_cnt == 3) begin
          bus_ack = 1'b1; bus_cnt = 0;
        end
      end
    end
  end

  // monitor: builds signatures from the ports and compares with the scoreboard
  initial begin
    logic [5:0] sig;
    bit stall_bad, bus_q;
    logic [1:0] rises;
    logic op_seen;
    sig = '0; stall_bad = 0; bus_q = 0; rises = '0; op_seen = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (!hold_req_n) sig[5] = 1'b1;
      if (!snp_dirty_n) sig[4] = 1'b1;
      if (l1_snp_req) begin
        sig[3] = 1'b1;
        if (l1_snp_kill) sig[2] = 1'b1;
        if (snp_ready || cpu_ready) stall_bad = 1'b1;
      end
      if (mem_wb_req) begin
        sig[1] = 1'b1;
        if (snp_ready || cpu_ready) stall_bad = 1'b1;
      end
      if (!snp_hit_n && snp_dirty_n && hold_req_n) sig[0] = 1'b1;
      if (bus_req && !bus_q) rises++;
      if (bus_req) op_seen = bus_op;
      bus_q = bus_req;
      if (snp_done) begin
        compare(1'b0, sig);
        n_chk++;
        if (stall_bad || snp_ready || cpu_ready) begin
          n_bad++;
          $display("FAIL R13 snoop busy: got ready/stall seen expected none");
        end
        sig = '0; stall_bad = 0;
      end
      if (rsp_valid) begin
        compare(1'b1, {2'b00, rsp_l1_own, op_seen, rises});
        rises = '0; op_seen = 0;
      end
    end
  end

  task automatic compare(input bit is_rsp, input logic [5:0] got);
    exp_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL R13 unexpected event: got %b expected nothing", got);
    end else begin
      e = exp_q.pop_front();
      if (e.is_rsp != is_rsp || e.val !== got) begin
        n_bad++;
        $display("FAIL %s: got %b (rsp=%0d) expected %b (rsp=%0d)",
                 e.tag, got, is_rsp, e.val, e.is_rsp);
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R13 watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; snp_valid = 0; snp_write = 0; snp_idx = '0;
    cpu_valid = 0; cpu_write = 0; cpu_idx = '0; fill_shared_n = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: idle outputs after reset
    n_chk++;
    if ({snp_hit_n, snp_dirty_n, hold_req_n, l1_snp_req, mem_wb_req, bus_req, rsp_valid,
         snp_ready, cpu_ready} !== 9'b111000011) begin
      n_bad++;
      $display("FAIL R1 idle outputs: got %b expected %b",
               {snp_hit_n, snp_dirty_n, hold_req_n, l1_snp_req, mem_wb_req, bus_req, rsp_valid,
                snp_ready, cpu_ready}, 9'b111000011);
    end
    // R1 R7: every line invalid, snoops miss silently
    for (int i = 0; i < 4; i++) snoop(IDX_W'(i), 1'b0, 1'b0, 6'b000000, "R1 R7 reset miss");

    // R9: fill with no other copy -> E, no ownership to L1
    cpu(2'd0, 1'b0, 1'b1, 1'b0, 6'b000001, "R9 fill exclusive");
    // R2 R3 R4 R5 R6: read snoop on clean E, no write-back, shared pulse
    snoop(2'd0, 1'b0, 1'b0, 6'b111001, "R2 R3 R4 R5 R6 read snoop clean E");
    // R7: now S, read snoop only pulses hit
    snoop(2'd0, 1'b0, 1'b0, 6'b000001, "R7 read snoop S");
    // R11: write to S invalidates other copy, becomes E
    cpu(2'd0, 1'b1, 1'b1, 1'b0, 6'b000101, "R11 write S invalidate");
    // R10: first write to E -> M, L1 gets ownership
    cpu(2'd0, 1'b1, 1'b1, 1'b0, 6'b001000, "R10 write E");
    // R10: write to M
    cpu(2'd0, 1'b1, 1'b1, 1'b0, 6'b001000, "R10 write M");
    // R3 R4 R5: write snoop on M -> kill, write-back, ends I
    snoop(2'd0, 1'b1, 1'b0, 6'b111110, "R3 R4 R5 write snoop M");
    snoop(2'd0, 1'b0, 1'b0, 6'b000000, "R5 line now I");

    // R9: fill while other cache hits -> S
    cpu(2'd1, 1'b0, 1'b0, 1'b0, 6'b000001, "R9 fill shared");
    snoop(2'd1, 1'b0, 1'b0, 6'b000001, "R9 shared fill state");
    // R8: write snoop on S -> invalidate, L1 kill, no hold
    snoop(2'd1, 1'b1, 1'b0, 6'b001100, "R8 write snoop S");
    snoop(2'd1, 1'b0, 1'b0, 6'b000000, "R8 line now I");

    // R4 R6: E line with dirty L1 copy -> write-back then shared pulse
    cpu(2'd2, 1'b0, 1'b1, 1'b0, 6'b000001, "R9 fill exclusive 2");
    snoop(2'd2, 1'b0, 1'b1, 6'b111011, "R4 R6 read snoop dirty L1");
    // R9: read hit without bus cycle
    cpu(2'd2, 1'b0, 1'b1, 1'b0, 6'b000000, "R9 read hit");

    // R11: write to I is a write-through, line stays I
    cpu(2'd3, 1'b1, 1'b1, 1'b0, 6'b000101, "R11 write-through I");
    snoop(2'd3, 1'b0, 1'b0, 6'b000000, "R11 line stays I");
    // R12: hold from the other side aborts and retries the fill
    cpu(2'd3, 1'b0, 1'b1, 1'b1, 6'b000010, "R12 backed-off fill");
    snoop(2'd3, 1'b1, 1'b0, 6'b111100, "R12 R3 write snoop clean E");

    // R13: request arriving during a snoop waits for its end
    fork
      snoop(2'd2, 1'b1, 1'b0, 6'b001100, "R13 R8 snoop with pending request");
      begin
        @(negedge clk); @(negedge clk);
        cpu(2'd1, 1'b1, 1'b1, 1'b0, 6'b000101, "R13 R11 stalled request");
      end
    join

    repeat (4) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R13 leftover: got %0d expected 0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule